// File: doc/BRIEF.md
# Event Timer Register Front End

This block is the register-facing half of a multi-channel event timer. It sits on a plain 32-bit register bus and decodes the global registers: capability, general configuration, interrupt status and main counter. It also decodes a set of fixed-size per-channel windows and passes channel accesses on to the channel logic through write strobes and a read-select path. It owns the 64-bit main counter. The counter advances on a tick enable while the global run bit is set and holds its value while that bit is clear. Software can load the counter one 32-bit half at a time.

Changing the global run bit has side effects on the channels. When the bit goes from 0 to 1, the block sends an arm pulse to every implemented channel whose comparator is not saturated. When the bit goes from 1 to 0, it sends a disarm pulse and an interrupt-clear pulse to every implemented channel. The capability word reports how many channels are built and the tick period. The build-time channel count is clamped to a range of at least three and at most a parameter.

Top module: `evt_timer_regs`

## Requirements
- R1: After reset, the main counter reads 0 and the general configuration word (offset 0x010) reads 0.
- R2: The word at offset 0x000 reads 0x8086A001 with bits 12:8 set to the implemented channel count minus one. The word at 0x004 reads the tick period in femtoseconds. Writes to either word change nothing.
- R3: Only bits 1:0 of the configuration word can be written (bit 0 = run, bit 1 = alternate routing); every other bit reads 0. The word at 0x014 reads 0 and ignores writes.
- R4: While run is 1, the counter increases by exactly one on each clock with tick_en high. While run is 0, the counter holds its value.
- R5: A write to 0x0F0 replaces counter bits 31:0, and a write to 0x0F4 replaces bits 63:32. The other half is kept, and in the cycle of the write the written value wins over any tick.
- R6: A write that takes run from 0 to 1 pulses ch_arm on the next cycle, for one cycle. The pulse covers each implemented channel whose ch_cmp_max bit is 0.
- R7: A write that takes run from 1 to 0 pulses ch_disarm and ch_irq_clr on the next cycle, for one cycle, for every implemented channel.
- R8: The word at 0x020 reads ch_irq_stat masked to the implemented channels. Writing it pulses ch_irq_clr on the next cycle with the bits that are 1 in both the written data and the status.
- R9: A write inside channel window n (base 0x100 + 0x20*n, word index = address bits 4:2) pulses bit n of ch_wr_en on the next cycle, together with the word index and the data. A read inside the window presents n on ch_rd_idx and returns ch_rd_data.
- R10: An access to a channel window whose index is at or beyond the implemented count reads 0 and produces no strobe.
- R11: The implemented count is NUM_CH clamped to the range 3 to MAX_CH, and this clamped count is what appears in capability bits 12:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the access |
| tick_en | input | 1 | Counter advance enable |
| count_o | output | CNT_W | Main counter value |
| ch_rd_idx | output | IDX_W | Channel index decoded from the address |
| ch_rd_word | output | 3 | Word index within the channel window |
| ch_rd_data | input | 32 | Read data returned by the addressed channel |
| ch_cmp_max | input | MAX_CH | Per-channel comparator-saturated flag |
| ch_irq_stat | input | MAX_CH | Per-channel interrupt status |
| ch_wr_en | output | MAX_CH | One-hot channel write strobe |
| ch_wr_word | output | 3 | Word index of the channel write |
| ch_wr_data | output | 32 | Data of the channel write |
| ch_arm | output | MAX_CH | Arm pulse per channel |
| ch_disarm | output | MAX_CH | Disarm pulse per channel |
| ch_irq_clr | output | MAX_CH | Interrupt clear pulse per channel |

## Verification
The assertions assume that at most one access is presented per cycle and that addresses are word aligned. They also assume that ch_irq_stat holds steady around a status write, so that the clear pulse can be compared against the status sampled one cycle earlier. The stimulus drives each access for exactly one cycle, changes the channel inputs only while no status write is in flight, and uses only aligned offsets. Those offsets cover in-range windows, out-of-range windows, unmapped words and both halves of each 64-bit register.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    localparam int ADDR_W = 10;
    localparam int WORD_W = 32;

    localparam logic [31:0] CAP_BASE = 32'h8086_A001;
    localparam logic [1:0]  CFG_WMASK = 2'b11;

    typedef enum logic [2:0] {
        RGN_CAP,
        RGN_CFG,
        RGN_STAT,
        RGN_CNT,
        RGN_CHAN,
        RGN_NONE
    } rgn_e;

    typedef struct packed {
        rgn_e       rgn;
        logic       hi;
        logic [4:0] chan;
        logic [2:0] word;
    } dec_t;

    typedef struct packed {
        logic alt_route;
        logic run;
    } gcfg_t;

endpackage

// File: rtl/evt_addr_dec.sv
module evt_addr_dec
    import evt_timer_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    always_comb begin
        dec      = '0;
        dec.rgn  = RGN_NONE;
        dec.hi   = addr[2];
        dec.word = addr[4:2];
        dec.chan = addr[9:5] - 5'd8;
        if (addr[9:8] != 2'b00) begin
            dec.rgn = RGN_CHAN;
        end else begin
            case (addr[7:3])
                5'h00:   dec.rgn = RGN_CAP;
                5'h02:   dec.rgn = RGN_CFG;
                5'h04:   dec.rgn = RGN_STAT;
                5'h1E:   dec.rgn = RGN_CNT;
                default: dec.rgn = RGN_NONE;
            endcase
        end
    end

endmodule

// File: rtl/evt_main_cnt.sv
module evt_main_cnt #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [31:0]      wdata,
    output logic [CNT_W-1:0] cnt_o
);

    localparam int HI_W = CNT_W - 32;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (wr_lo) begin
            cnt_d[31:0] = wdata;
        end
        if (wr_hi) begin
            cnt_d[CNT_W-1:32] = wdata[HI_W-1:0];
        end
        if (!wr_lo && !wr_hi && run) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/evt_ch_fanout.sv
module evt_ch_fanout #(
    parameter int                 MAX_CH    = 8,
    parameter int                 IDX_W     = 3,
    parameter logic [MAX_CH-1:0]  IMPL_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ch_wr,
    input  logic [IDX_W-1:0]  ch_idx,
    input  logic [2:0]        word,
    input  logic [31:0]       wdata,
    input  logic              en_rise,
    input  logic              en_fall,
    input  logic              stat_wr,
    input  logic [MAX_CH-1:0] cmp_max,
    input  logic [MAX_CH-1:0] irq_stat,
    output logic [MAX_CH-1:0] wr_en_o,
    output logic [2:0]        word_o,
    output logic [31:0]       data_o,
    output logic [MAX_CH-1:0] arm_o,
    output logic [MAX_CH-1:0] disarm_o,
    output logic [MAX_CH-1:0] clr_o
);

    typedef struct packed {
        logic [MAX_CH-1:0] wr_en;
        logic [2:0]        word;
        logic [31:0]       data;
        logic [MAX_CH-1:0] arm;
        logic [MAX_CH-1:0] disarm;
        logic [MAX_CH-1:0] clr;
    } strobe_t;

    strobe_t st_d, st_q;
    logic [MAX_CH-1:0] sel_vec;

    generate
        for (genvar g = 0; g < MAX_CH; g++) begin : g_sel
            assign sel_vec[g] = ch_wr && (ch_idx == IDX_W'(g)) && IMPL_MASK[g];
        end
    endgenerate

    always_comb begin
        st_d        = '0;
        st_d.word   = st_q.word;
        st_d.data   = st_q.data;
        if (ch_wr) begin
            st_d.wr_en = sel_vec;
            st_d.word  = word;
            st_d.data  = wdata;
        end
        if (en_rise) begin
            st_d.arm = IMPL_MASK & ~cmp_max;
        end
        if (en_fall) begin
            st_d.disarm = IMPL_MASK;
            st_d.clr    = IMPL_MASK;
        end else if (stat_wr) begin
            st_d.clr = IMPL_MASK & irq_stat & wdata[MAX_CH-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en_o  = st_q.wr_en;
    assign word_o   = st_q.word;
    assign data_o   = st_q.data;
    assign arm_o    = st_q.arm;
    assign disarm_o = st_q.disarm;
    assign clr_o    = st_q.clr;

endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
    import evt_timer_pkg::*;
#(
    parameter int          NUM_CH  = 4,
    parameter int          MAX_CH  = 8,
    parameter int          CNT_W   = 64,
    parameter logic [31:0] TICK_FS = 32'd10_000_000,
    localparam int         IDX_W   = (MAX_CH > 1) ? $clog2(MAX_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [9:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick_en,
    output logic [CNT_W-1:0]  count_o,
    output logic [IDX_W-1:0]  ch_rd_idx,
    output logic [2:0]        ch_rd_word,
    input  logic [31:0]       ch_rd_data,
    input  logic [MAX_CH-1:0] ch_cmp_max,
    input  logic [MAX_CH-1:0] ch_irq_stat,
    output logic [MAX_CH-1:0] ch_wr_en,
    output logic [2:0]        ch_wr_word,
    output logic [31:0]       ch_wr_data,
    output logic [MAX_CH-1:0] ch_arm,
    output logic [MAX_CH-1:0] ch_disarm,
    output logic [MAX_CH-1:0] ch_irq_clr
);

    localparam int MIN_CH = 3;
    localparam int NCH = (NUM_CH < MIN_CH) ? MIN_CH :
                         (NUM_CH > MAX_CH) ? MAX_CH : NUM_CH;
    localparam logic [MAX_CH-1:0] IMPL_MASK = {MAX_CH{1'b1}} >> (MAX_CH - NCH);
    localparam logic [31:0] CAP_LO = CAP_BASE | (32'(NCH - 1) << 8);

    dec_t  dec;
    gcfg_t cfg_d, cfg_q;
    logic  wr_acc, ch_in_range;
    logic  wr_cfg, en_rise, en_fall;
    logic  wr_cnt_lo, wr_cnt_hi, cnt_wr_any;
    logic  wr_stat, wr_chan;
    logic  glb_run;
    logic [31:0] rd_mux;

    evt_addr_dec u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    assign wr_acc      = bus_sel && bus_we;
    assign ch_in_range = (dec.chan < 5'(NCH));
    assign wr_cfg      = wr_acc && (dec.rgn == RGN_CFG) && !dec.hi;
    assign wr_cnt_lo   = wr_acc && (dec.rgn == RGN_CNT) && !dec.hi;
    assign wr_cnt_hi   = wr_acc && (dec.rgn == RGN_CNT) && dec.hi;
    assign cnt_wr_any  = wr_cnt_lo || wr_cnt_hi;
    assign wr_stat     = wr_acc && (dec.rgn == RGN_STAT) && !dec.hi;
    assign wr_chan     = wr_acc && (dec.rgn == RGN_CHAN) && ch_in_range;
    assign en_rise     = wr_cfg && !cfg_q.run && bus_wdata[0];
    assign en_fall     = wr_cfg && cfg_q.run && !bus_wdata[0];
    assign glb_run     = cfg_q.run;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_cfg) begin
            cfg_d = gcfg_t'((bus_wdata[1:0] & CFG_WMASK) | (cfg_q & ~CFG_WMASK));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    evt_main_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (glb_run && tick_en),
        .wr_lo (wr_cnt_lo),
        .wr_hi (wr_cnt_hi),
        .wdata (bus_wdata),
        .cnt_o (count_o)
    );

    evt_ch_fanout #(
        .MAX_CH    (MAX_CH),
        .IDX_W     (IDX_W),
        .IMPL_MASK (IMPL_MASK)
    ) u_fan (
        .clk      (clk),
        .rst_n    (rst_n),
        .ch_wr    (wr_chan),
        .ch_idx   (dec.chan[IDX_W-1:0]),
        .word     (dec.word),
        .wdata    (bus_wdata),
        .en_rise  (en_rise),
        .en_fall  (en_fall),
        .stat_wr  (wr_stat),
        .cmp_max  (ch_cmp_max),
        .irq_stat (ch_irq_stat),
        .wr_en_o  (ch_wr_en),
        .word_o   (ch_wr_word),
        .data_o   (ch_wr_data),
        .arm_o    (ch_arm),
        .disarm_o (ch_disarm),
        .clr_o    (ch_irq_clr)
    );

    assign ch_rd_idx  = dec.chan[IDX_W-1:0];
    assign ch_rd_word = dec.word;

    always_comb begin
        rd_mux = '0;
        case (dec.rgn)
            RGN_CAP:  rd_mux = dec.hi ? TICK_FS : CAP_LO;
            RGN_CFG:  rd_mux = dec.hi ? 32'd0 : {30'd0, cfg_q};
            RGN_STAT: rd_mux = dec.hi ? 32'd0 : 32'(ch_irq_stat & IMPL_MASK);
            RGN_CNT:  rd_mux = dec.hi ? 32'(count_o[CNT_W-1:32]) : count_o[31:0];
            RGN_CHAN: rd_mux = ch_in_range ? ch_rd_data : 32'd0;
            default:  rd_mux = '0;
        endcase
    end

    assign bus_rdata = bus_sel ? rd_mux : 32'd0;

endmodule

// File: rtl/evt_timer_regs_chk.sv
module evt_timer_regs_chk #(
    parameter int MAX_CH = 8,
    parameter int CNT_W  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              run_now,
    input logic              cnt_wr,
    input logic [CNT_W-1:0]  count_o,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [9:0]        bus_addr,
    input logic [31:0]       bus_rdata,
    input logic [MAX_CH-1:0] ch_arm,
    input logic [MAX_CH-1:0] ch_disarm,
    input logic [MAX_CH-1:0] ch_irq_clr,
    input logic [MAX_CH-1:0] ch_irq_stat,
    input logic [MAX_CH-1:0] ch_wr_en
);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_now && tick_en && !cnt_wr) |=> (count_o == $past(count_o) + 1'b1)); // R4

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_now && !cnt_wr) |=> $stable(count_o)); // R4

    AST_ARM_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_arm) |-> run_now); // R6

    AST_DISARM_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_disarm) |-> (!run_now && ch_irq_clr == ch_disarm)); // R7

    AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_wr_en)); // R9

    AST_CLR_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == 10'h020) |=>
            ((ch_irq_clr & ~$past(ch_irq_stat)) == '0)); // R8

    AST_CAP_SIG: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr == 10'h000) |-> (bus_rdata[31:16] == 16'h8086)); // R2

endmodule

bind evt_timer_regs evt_timer_regs_chk #(
    .MAX_CH (MAX_CH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .run_now     (glb_run),
    .cnt_wr      (cnt_wr_any),
    .count_o     (count_o),
    .bus_sel     (bus_sel),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .ch_arm      (ch_arm),
    .ch_disarm   (ch_disarm),
    .ch_irq_clr  (ch_irq_clr),
    .ch_irq_stat (ch_irq_stat),
    .ch_wr_en    (ch_wr_en)
);

// File: tb/evt_timer_regs_tb.sv
`timescale 1ns/1ps
module evt_timer_regs_tb;

    localparam int MAXC = 8;
    localparam int NCHX = 4;
    localparam logic [31:0] TFS = 32'd10_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        tick_en = 1'b0;
    logic [31:0] ch_rd_data = 32'h5A5A_1234;
    logic [MAXC-1:0] ch_cmp_max = '0, ch_irq_stat = '0;

    logic [31:0] bus_rdata, rd_lo, rd_hi;
    logic [63:0] count_o, cnt_lo, cnt_hi;
    logic [2:0]  ch_rd_idx, ri_lo, ri_hi;
    logic [2:0]  ch_rd_word, rw_lo, rw_hi, ch_wr_word, ww_lo, ww_hi;
    logic [31:0] ch_wr_data, wd_lo, wd_hi;
    logic [MAXC-1:0] ch_wr_en, ch_arm, ch_disarm, ch_irq_clr;
    logic [MAXC-1:0] we_lo, ar_lo, di_lo, cl_lo, we_hi, ar_hi, di_hi, cl_hi;

    always #2.5 clk = ~clk;

    evt_timer_regs #(.NUM_CH(NCHX), .MAX_CH(MAXC)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_en(tick_en), .count_o(count_o), .ch_rd_idx(ch_rd_idx),
        .ch_rd_word(ch_rd_word), .ch_rd_data(ch_rd_data), .ch_cmp_max(ch_cmp_max),
        .ch_irq_stat(ch_irq_stat), .ch_wr_en(ch_wr_en), .ch_wr_word(ch_wr_word),
        .ch_wr_data(ch_wr_data), .ch_arm(ch_arm), .ch_disarm(ch_disarm),
        .ch_irq_clr(ch_irq_clr));

    evt_timer_regs #(.NUM_CH(1), .MAX_CH(MAXC)) u_dut_lo (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_lo),
        .tick_en(tick_en), .count_o(cnt_lo), .ch_rd_idx(ri_lo),
        .ch_rd_word(rw_lo), .ch_rd_data(ch_rd_data), .ch_cmp_max(ch_cmp_max),
        .ch_irq_stat(ch_irq_stat), .ch_wr_en(we_lo), .ch_wr_word(ww_lo),
        .ch_wr_data(wd_lo), .ch_arm(ar_lo), .ch_disarm(di_lo), .ch_irq_clr(cl_lo));

    evt_timer_regs #(.NUM_CH(30), .MAX_CH(MAXC)) u_dut_hi (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_hi),
        .tick_en(tick_en), .count_o(cnt_hi), .ch_rd_idx(ri_hi),
        .ch_rd_word(rw_hi), .ch_rd_data(ch_rd_data), .ch_cmp_max(ch_cmp_max),
        .ch_irq_stat(ch_irq_stat), .ch_wr_en(we_hi), .ch_wr_word(ww_hi),
        .ch_wr_data(wd_hi), .ch_arm(ar_hi), .ch_disarm(di_hi), .ch_irq_clr(cl_hi));

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    logic [63:0]     m_cnt;
    logic [1:0]      m_cfg;
    logic [MAXC-1:0] e_wr, e_arm, e_dis, e_clr;
    logic [2:0]      e_word;
    logic [31:0]     e_data;
    logic [MAXC-1:0] impl;
    assign impl = MAXC'((1 << NCHX) - 1);

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = '0; m_cfg = '0;
            e_wr = '0; e_arm = '0; e_dis = '0; e_clr = '0; e_word = '0; e_data = '0;
        end else begin
            automatic bit was_run = m_cfg[0];
            automatic bit cnt_written = 1'b0;
            e_wr = '0; e_arm = '0; e_dis = '0; e_clr = '0;
            if (bus_sel && bus_we) begin
                if (bus_addr == 10'h010) begin
                    if (!was_run && bus_wdata[0]) e_arm = impl & ~ch_cmp_max;
                    if (was_run && !bus_wdata[0]) begin
                        e_dis = impl; e_clr = impl;
                    end
                    m_cfg = bus_wdata[1:0];
                end else if (bus_addr == 10'h020) begin
                    e_clr = impl & ch_irq_stat & bus_wdata[MAXC-1:0];
                end else if (bus_addr == 10'h0F0) begin
                    m_cnt[31:0] = bus_wdata; cnt_written = 1'b1;
                end else if (bus_addr == 10'h0F4) begin
                    m_cnt[63:32] = bus_wdata; cnt_written = 1'b1;
                end else if (bus_addr >= 10'h100) begin
                    automatic int idx = (int'(bus_addr) - 256) / 32;
                    if (idx < NCHX) begin
                        e_wr = MAXC'(1 << idx);
                        e_word = bus_addr[4:2];
                        e_data = bus_wdata;
                    end
                end
            end
            if (!cnt_written && was_run && tick_en) m_cnt = m_cnt + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(count_o == m_cnt, "R4 R5 counter", count_o, m_cnt);
            chk(ch_arm == e_arm, "R6 arm", 64'(ch_arm), 64'(e_arm));
            chk(ch_disarm == e_dis, "R7 disarm", 64'(ch_disarm), 64'(e_dis));
            chk(ch_irq_clr == e_clr, "R7 R8 irq clear", 64'(ch_irq_clr), 64'(e_clr));
            chk(ch_wr_en == e_wr, "R9 R10 write strobe", 64'(ch_wr_en), 64'(e_wr));
            if (e_wr != '0) begin
                chk(ch_wr_word == e_word, "R9 write word", 64'(ch_wr_word), 64'(e_word));
                chk(ch_wr_data == e_data, "R9 write data", 64'(ch_wr_data), 64'(e_data));
            end
        end
    end

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #0.5;
        chk(bus_rdata == exp, tag, 64'(bus_rdata), 64'(exp));
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(10'h0F0, 32'd0, "R1 counter low");
        rd(10'h0F4, 32'd0, "R1 counter high");
        rd(10'h010, 32'd0, "R1 config");
        // R2 capability
        rd(10'h000, 32'h8086_A301, "R2 capability low");
        rd(10'h004, TFS, "R2 tick period");
        wr(10'h000, 32'h0);
        wr(10'h004, 32'h1);
        rd(10'h000, 32'h8086_A301, "R2 capability after write");
        rd(10'h004, TFS, "R2 period after write");
        // R11 clamping
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 10'h000;
        #0.5;
        chk(rd_lo == 32'h8086_A201, "R11 clamp to minimum", 64'(rd_lo), 64'h8086_A201);
        chk(rd_hi == 32'h8086_A701, "R11 clamp to maximum", 64'(rd_hi), 64'h8086_A701);
        bus_sel = 1'b0;
        // R5 halves while halted, R4 frozen
        tick_en = 1'b1;
        wr(10'h0F0, 32'hFFFF_FFFE);
        wr(10'h0F4, 32'h0000_0001);
        idle(4);
        rd(10'h0F0, 32'hFFFF_FFFE, "R4 held low");
        rd(10'h0F4, 32'h0000_0001, "R5 high half");
        // R6 enable with channel 2 saturated
        ch_cmp_max = 8'b0000_0100;
        wr(10'h010, 32'h1);
        idle(5);
        tick_en = 1'b0;
        idle(2);
        rd(10'h0F4, 32'h0000_0002, "R4 carry into high half");
        tick_en = 1'b1;
        // R3 mask
        wr(10'h010, 32'hFFFF_FFFF);
        rd(10'h010, 32'h3, "R3 masked config");
        wr(10'h014, 32'hFFFF_FFFF);
        rd(10'h014, 32'h0, "R3 config high word");
        // R5 write wins over tick
        wr(10'h0F0, 32'h0000_0100);
        idle(2);
        // R8 status
        ch_irq_stat = 8'b1111_0110;
        rd(10'h020, 32'h6, "R8 status read masked");
        wr(10'h020, 32'h0000_00FF);
        wr(10'h020, 32'h0000_0002);
        // R9 channel writes and reads
        wr(10'h148, 32'hDEAD_BEEF);
        wr(10'h170, 32'h1234_5678);
        rd(10'h168, 32'h5A5A_1234, "R9 channel read");
        chk(ch_rd_idx == 3'd3 && ch_rd_word == 3'd2, "R9 read index",
            64'({ch_rd_idx, ch_rd_word}), 64'({3'd3, 3'd2}));
        // R10 out of range
        wr(10'h1A0, 32'hFFFF_FFFF);
        wr(10'h3E4, 32'hFFFF_FFFF);
        rd(10'h1A0, 32'h0, "R10 out of range read");
        rd(10'h3FC, 32'h0, "R10 last window read");
        // R7 disable
        wr(10'h010, 32'h2);
        idle(4);
        rd(10'h010, 32'h2, "R7 halted config");
        // R6 re-enable with all saturated
        ch_cmp_max = 8'hFF;
        wr(10'h010, 32'h1);
        idle(3);
        wr(10'h010, 32'h0);
        idle(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule